// File: doc/BRIEF.md
# AES-128 Round-per-Cycle Encryptor

This block encrypts a single 128-bit block under a 128-bit key with an iterative datapath. Each clock computes one complete cipher round: byte substitution through a lookup, row rotation, column mixing and round-key addition. The key schedule runs beside the datapath and derives each round key in the cycle where that key is used. No round-key storage is needed.

A caller places a plaintext and a key on the input buses and pulses `start` for one cycle. The block captures both buses, performs the whitening key addition, runs ten rounds and then presents the ciphertext for a single cycle while `done` is high. At all other times the ciphertext bus is driven to zero. A block occupies the engine for twelve clock edges. The engine accepts a new `start` on the same cycle that `done` is shown, so blocks can be issued back to back. Any `start` that arrives while a block is still in flight is dropped.

Top module: `aes128_core`

## Requirements
- R1: For any 128-bit key and plaintext, the value shown with `done` equals the AES-128 encryption of that plaintext. This includes the published known-answer pairs.
- R2: Byte k of a bus (k = 0..15) occupies bits [127-8k:120-8k]. Byte k maps to state row k mod 4, column k div 4. This holds for plaintext, key and ciphertext.
- R3: `start` is accepted on rising edge E only when the engine is idle. `done` is then high for exactly one cycle, in the cycle after edge E+11, and at no other time.
- R4: Whenever `done` is low, `ciphertext` is all zeros.
- R5: A `start` seen while a block is in flight is ignored. It does not change that block's result, does not produce an extra `done`, and does not start a new block.
- R6: The engine is idle in the cycle where `done` is high. A `start` held high through that cycle launches the next block, giving one result every 12 cycles.
- R7: A synchronous active-high `rst` abandons any block in flight. After the reset edge, `done` is 0, `ciphertext` is 0 and the engine is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launches one block when the engine is idle |
| plaintext | input | 128 | Block to encrypt, captured on the accepting edge |
| key | input | 128 | Cipher key, captured on the accepting edge |
| ciphertext | output | 128 | Result while `done` is high, zero otherwise |
| done | output | 1 | One-cycle result strobe |

## Verification
The hardest situations to reach from the ports are a `start` that lands in the middle of a block, and a `start` that lands exactly on the cycle where the previous result appears. The bench reaches the first by pulsing `start` with different data four cycles into a block. It reaches the second by holding `start` high across three consecutive blocks, so every acceptance falls on a `done` cycle. A reset issued mid-block checks that a partly computed state never emerges. A behavioural model with its own S-box derivation predicts `done` and the ciphertext bus on every clock.

// File: rtl/aes128_pkg.sv
package aes128_pkg;

    localparam int BLOCK_W = 128;
    localparam int BYTE_W  = 8;
    localparam int NBYTES  = BLOCK_W / BYTE_W;
    localparam int NCOLS   = 4;
    localparam int NROWS   = NBYTES / NCOLS;
    localparam int WORD_W  = NROWS * BYTE_W;
    localparam int NR      = 10;
    localparam int CNT_W   = $clog2(NR + 2);

    typedef logic [BYTE_W-1:0]  byte_t;
    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [BLOCK_W-1:0] block_t;
    typedef logic [CNT_W-1:0]   rnd_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ROUND = 2'd1,
        PH_EMIT  = 2'd2
    } phase_e;

    // Control strobes from the sequencer to the datapath
    typedef struct packed {
        logic load;
        logic round_en;
        logic last_round;
        logic emit;
        logic busy;
        rnd_t rnd;
    } ctrl_t;

    function automatic byte_t xtime(byte_t a);
        return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gf_mul(byte_t a, byte_t b);
        byte_t acc = '0;
        byte_t x   = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ x;
            x = xtime(x);
        end
        return acc;
    endfunction

    // Multiplicative inverse as a^254 (zero maps to zero)
    function automatic byte_t gf_inv(byte_t a);
        byte_t r = 8'h01;
        byte_t p = a;
        for (int i = 1; i < BYTE_W; i++) begin
            p = gf_mul(p, p);
            r = gf_mul(r, p);
        end
        return r;
    endfunction

    function automatic byte_t rotl8(byte_t v, int n);
        return byte_t'((v << n) | (v >> (BYTE_W - n)));
    endfunction

    function automatic byte_t sbox_fn(byte_t a);
        byte_t b = gf_inv(a);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

    // Round constant for round k (1-based): 01, 02, 04, ... , 1B, 36
    function automatic byte_t rcon_fn(rnd_t k);
        byte_t r = 8'h01;
        for (int i = 1; i <= NR; i++) begin
            if (rnd_t'(i) < k) r = xtime(r);
        end
        return r;
    endfunction

endpackage

// File: rtl/aes128_sbox.sv
module aes128_sbox
    import aes128_pkg::*;
(
    input  byte_t in_byte,
    output byte_t out_byte
);
    always_comb out_byte = sbox_fn(in_byte);
endmodule

// File: rtl/aes128_keystep.sv
module aes128_keystep
    import aes128_pkg::*;
(
    input  block_t rk_cur,
    input  byte_t  rcon,
    output block_t rk_next
);
    word_t w_in  [NCOLS];
    word_t w_out [NCOLS];
    word_t rot_w;
    word_t sub_w;
    word_t mix_w;

    for (genvar c = 0; c < NCOLS; c++) begin : g_split
        assign w_in[c] = rk_cur[BLOCK_W-1-WORD_W*c -: WORD_W];
        assign rk_next[BLOCK_W-1-WORD_W*c -: WORD_W] = w_out[c];
    end

    assign rot_w = {w_in[NCOLS-1][WORD_W-BYTE_W-1:0], w_in[NCOLS-1][WORD_W-1 -: BYTE_W]};

    for (genvar r = 0; r < NROWS; r++) begin : g_sub
        aes128_sbox u_sbox (
            .in_byte  (rot_w[WORD_W-1-BYTE_W*r -: BYTE_W]),
            .out_byte (sub_w[WORD_W-1-BYTE_W*r -: BYTE_W])
        );
    end

    assign mix_w = sub_w ^ {rcon, {(WORD_W-BYTE_W){1'b0}}};

    always_comb begin
        w_out[0] = w_in[0] ^ mix_w;
        for (int c = 1; c < NCOLS; c++) begin
            w_out[c] = w_in[c] ^ w_out[c-1];
        end
    end
endmodule

// File: rtl/aes128_round.sv
module aes128_round
    import aes128_pkg::*;
(
    input  block_t st_in,
    input  block_t rk,
    input  logic   skip_mix,
    output block_t st_out
);
    byte_t sub_b   [NBYTES];
    byte_t shift_b [NBYTES];
    byte_t mix_b   [NBYTES];

    for (genvar i = 0; i < NBYTES; i++) begin : g_sub
        aes128_sbox u_sbox (
            .in_byte  (st_in[BLOCK_W-1-BYTE_W*i -: BYTE_W]),
            .out_byte (sub_b[i])
        );
    end

    // Row r rotates left by r positions
    for (genvar c = 0; c < NCOLS; c++) begin : g_col
        for (genvar r = 0; r < NROWS; r++) begin : g_row
            assign shift_b[NROWS*c+r] = sub_b[NROWS*((c+r)%NCOLS)+r];
        end
    end

    always_comb begin
        for (int c = 0; c < NCOLS; c++) begin
            byte_t a0, a1, a2, a3;
            a0 = shift_b[NROWS*c];
            a1 = shift_b[NROWS*c+1];
            a2 = shift_b[NROWS*c+2];
            a3 = shift_b[NROWS*c+3];
            mix_b[NROWS*c]   = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
            mix_b[NROWS*c+1] = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
            mix_b[NROWS*c+2] = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
            mix_b[NROWS*c+3] = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
        end
    end

    always_comb begin
        st_out = '0;
        for (int i = 0; i < NBYTES; i++) begin
            st_out[BLOCK_W-1-BYTE_W*i -: BYTE_W] =
                (skip_mix ? shift_b[i] : mix_b[i]) ^ rk[BLOCK_W-1-BYTE_W*i -: BYTE_W];
        end
    end
endmodule

// File: rtl/aes128_ctrl.sv
module aes128_ctrl
    import aes128_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    output ctrl_t ctl
);
    phase_e phase_q;
    rnd_t   rnd_q;

    always_comb begin
        ctl.busy       = (phase_q != PH_IDLE);
        ctl.load       = (phase_q == PH_IDLE) && start;
        ctl.round_en   = (phase_q == PH_ROUND);
        ctl.last_round = (phase_q == PH_ROUND) && (rnd_q == rnd_t'(NR));
        ctl.emit       = (phase_q == PH_EMIT);
        ctl.rnd        = rnd_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            rnd_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_ROUND;
                        rnd_q   <= rnd_t'(1);
                    end
                end
                PH_ROUND: begin
                    if (rnd_q == rnd_t'(NR)) begin
                        phase_q <= PH_EMIT;
                    end else begin
                        rnd_q <= rnd_q + 1'b1;
                    end
                end
                PH_EMIT: begin
                    phase_q <= PH_IDLE;
                    rnd_q   <= '0;
                end
                default: begin
                    phase_q <= PH_IDLE;
                    rnd_q   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/aes128_core.sv
module aes128_core
    import aes128_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [127:0] plaintext,
    input  logic [127:0] key,
    output logic [127:0] ciphertext,
    output logic         done
);
    ctrl_t  ctl;
    block_t state_q;
    block_t rk_q;
    block_t rk_nxt;
    block_t round_out;
    block_t ct_q;
    logic   done_q;
    byte_t  rcon;
    logic   busy;

    aes128_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctl   (ctl)
    );

    assign rcon = rcon_fn(ctl.rnd);
    assign busy = ctl.busy;

    aes128_keystep u_keystep (
        .rk_cur  (rk_q),
        .rcon    (rcon),
        .rk_next (rk_nxt)
    );

    aes128_round u_round (
        .st_in    (state_q),
        .rk       (rk_nxt),
        .skip_mix (ctl.last_round),
        .st_out   (round_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            rk_q    <= '0;
            ct_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            if (ctl.load) begin
                state_q <= plaintext ^ key;
                rk_q    <= key;
            end else if (ctl.round_en) begin
                state_q <= round_out;
                rk_q    <= rk_nxt;
            end
            done_q <= ctl.emit;
            ct_q   <= ctl.emit ? state_q : '0;
        end
    end

    assign ciphertext = ct_q;
    assign done       = done_q;
endmodule

// File: rtl/aes128_core_chk.sv
module aes128_core_chk (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [127:0] ct
);
    logic [3:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (left_q != 4'd0) begin
            left_q <= left_q - 4'd1;
        end else if (start) begin
            left_q <= 4'd11;
        end
    end

    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_on_time_R3: assert property (@(posedge clk) disable iff (rst)
        (left_q == 4'd1) |=> done);

    assert_no_stray_done_R3: assert property (@(posedge clk) disable iff (rst)
        (left_q != 4'd1) |=> !done);

    assert_ct_zero_R4: assert property (@(posedge clk) disable iff (rst)
        !done |-> (ct == '0));

    assert_busy_start_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));

    assert_idle_on_done_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_reset_clears_R7: assert property (@(posedge clk)
        rst |=> (!done && (ct == '0) && !busy));
endmodule

bind aes128_core aes128_core_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done),
    .ct    (ciphertext)
);

// File: tb/aes128_core_tb.sv
module aes128_core_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [127:0] pt = '0;
    logic [127:0] key = '0;
    logic [127:0] ct;
    logic         done;

    always #(CLK_PERIOD/2) clk = ~clk;

    aes128_core u_dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .plaintext  (pt),
        .key        (key),
        .ciphertext (ct),
        .done       (done)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] sb [256];

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] gm(logic [7:0] a, logic [7:0] b);
        logic [7:0] p = 0;
        for (int i = 0; i < 8; i++) begin
            logic hi;
            if (b[0]) p ^= a;
            hi = a[7];
            a = a << 1;
            if (hi) a ^= 8'h1b;
            b = b >> 1;
        end
        return p;
    endfunction

    initial begin
        for (int a = 0; a < 256; a++) begin
            logic [7:0] inv = 0;
            logic [7:0] s;
            logic [7:0] c = 8'h63;
            if (a != 0)
                for (int b = 1; b < 256; b++)
                    if (gm(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
            for (int i = 0; i < 8; i++)
                s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
            sb[a] = s;
        end
    end

    function automatic logic [127:0] ref_enc(logic [127:0] p, logic [127:0] k);
        logic [7:0]  s [16];
        logic [7:0]  t [16];
        logic [31:0] w [44];
        logic [7:0]  rc = 8'h01;
        logic [127:0] res;
        for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            logic [31:0] tmp = w[i-1];
            if (i % 4 == 0) begin
                tmp = {tmp[23:0], tmp[31:24]};
                tmp = {sb[tmp[31:24]] ^ rc, sb[tmp[23:16]], sb[tmp[15:8]], sb[tmp[7:0]]};
                rc = gm(rc, 8'h02);
            end
            w[i] = w[i-4] ^ tmp;
        end
        for (int i = 0; i < 16; i++) s[i] = p[127-8*i -: 8] ^ k[127-8*i -: 8];
        for (int rd = 1; rd <= 10; rd++) begin
            for (int i = 0; i < 16; i++) t[i] = sb[s[i]];
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++) s[4*c+r] = t[4*((c+r)%4)+r];
            if (rd < 10) begin
                for (int c = 0; c < 4; c++) begin
                    logic [7:0] col [4];
                    for (int r = 0; r < 4; r++) col[r] = s[4*c+r];
                    for (int r = 0; r < 4; r++)
                        s[4*c+r] = gm(col[r], 8'h02) ^ gm(col[(r+1)%4], 8'h03) ^ col[(r+2)%4] ^ col[(r+3)%4];
                end
            end
            for (int i = 0; i < 16; i++) s[i] ^= w[4*rd + i/4][31-8*(i%4) -: 8];
        end
        for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
        return res;
    endfunction

    // Cycle-level reference model
    int           m_left = 0;
    logic [127:0] m_pend = '0;
    logic [127:0] m_ct = '0;
    logic         m_done = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_left = 0;
            m_done = 1'b0;
            m_ct   = '0;
        end else begin
            int was;
            was = m_left;
            if (was > 0) m_left = was - 1;
            m_done = (was == 1);
            m_ct   = (was == 1) ? m_pend : '0;
            if (was == 0 && start) begin
                m_left = 11;
                m_pend = ref_enc(pt, key);
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(done === m_done, "R3 done strobe timing", {127'd0, done}, {127'd0, m_done});
            chk(ct === m_ct, "R4 ciphertext bus vs model", ct, m_ct);
        end
    end

    task automatic launch(input logic [127:0] p, input logic [127:0] k);
        @(negedge clk);
        pt = p; key = k; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Waits for done; returns cycles counted from the launching negedge
    task automatic wait_done(output int cyc, output logic [127:0] res, input int already);
        cyc = already;
        res = '0;
        for (int i = 0; i < 30; i++) begin
            if (done) begin
                res = ct;
                break;
            end
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic kat(input logic [127:0] p, input logic [127:0] k, input logic [127:0] exp, input string tag);
        int cyc;
        logic [127:0] res;
        launch(p, k);
        wait_done(cyc, res, 1);
        chk(res === exp, tag, res, exp);
        chk(cyc == 12, "R3 latency of 12 edges", 128'(cyc), 128'd12);
    endtask

    initial begin
        int cyc;
        int ndone;
        logic [127:0] res;
        logic [127:0] pa, ka;

        repeat (3) @(negedge clk);
        // R7: reset state
        chk(done === 1'b0, "R7 done low in reset", {127'd0, done}, 128'd0);
        chk(ct === '0, "R7 ciphertext zero in reset", ct, '0);
        rst = 1'b0;

        // R1/R2: published known-answer pairs
        kat(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f,
            128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R1 R2 known answer A");
        kat(128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c,
            128'h3925841d02dc09fbdc118597196a0b32, "R1 R2 known answer B");
        kat('0, '0, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, "R1 known answer zero");

        // R1: random blocks against the behavioural cipher
        for (int n = 0; n < 6; n++) begin
            pa = {$urandom, $urandom, $urandom, $urandom};
            ka = {$urandom, $urandom, $urandom, $urandom};
            kat(pa, ka, ref_enc(pa, ka), "R1 random block");
        end

        // R5: start during a block is ignored
        pa = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
        ka = 128'h00ff11ee22dd33cc44bb55aa66997788;
        launch(pa, ka);
        repeat (3) @(negedge clk);
        pt = ~pa; key = ~ka; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(cyc, res, 5);
        chk(res === ref_enc(pa, ka), "R5 in-flight start leaves result", res, ref_enc(pa, ka));
        chk(cyc == 12, "R5 in-flight start leaves timing", 128'(cyc), 128'd12);
        ndone = 0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (done) ndone++;
        end
        chk(ndone == 0, "R5 no extra done after ignored start", 128'(ndone), 128'd0);

        // R6: start held high -> back-to-back blocks
        @(negedge clk);
        pt = pa; key = ka; start = 1'b1;
        ndone = 0;
        for (int i = 0; i < 36; i++) begin
            @(negedge clk);
            if (done) begin
                ndone++;
                chk(ct === ref_enc(pa, ka), "R6 back-to-back result", ct, ref_enc(pa, ka));
            end
        end
        start = 1'b0;
        chk(ndone == 3, "R6 three results in 36 cycles", 128'(ndone), 128'd3);
        repeat (14) @(negedge clk);

        // R7: reset mid-block abandons it
        launch(pa, ka);
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(done === 1'b0 && ct === '0, "R7 reset mid-block clears outputs", ct, '0);
        rst = 1'b0;
        ndone = 0;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            if (done) ndone++;
        end
        chk(ndone == 0, "R7 abandoned block never completes", 128'(ndone), 128'd0);
        kat(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f,
            128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R7 R1 block after reset");

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL R3 watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule